// File: doc/BRIEF.md
# Register-Mapped Serial Port with Small Baud Divisor

This block is a compact asynchronous serial port that hangs off an 8-bit synchronous register bus inside a larger chip. Software reaches it through four byte-wide registers: a data register that takes a transmit byte on write and returns the last received byte on read, an interrupt enable register, a read-only line status register and a divisor register. Frames use one start bit, eight data bits sent least significant bit first, no parity and one stop bit.

The bit clock comes from a 16x oversampling tick. A fixed prescaler (`BASE_DIV` clock cycles) produces the base 16x tick, which belongs to the highest line rate. A 4-bit divisor then stretches it, so the line rate is the base rate divided by the divisor, and a divisor of zero halts the tick altogether. The receiver looks for a falling edge, confirms the start bit near its middle and samples every following bit at its centre. A single active-low interrupt line is driven only while at least one interrupt source is enabled. Otherwise its output enable is low and the pin is left to a pull-up.

Top module: `mmio_uart`

## Requirements
- R1: After reset the serial output is high, the divisor and interrupt enables read 0, line status reads 0x60 and the interrupt output enable is low.
- R2: Offset 0 is data, 1 is interrupt enable (bit 0 = transmit-empty, bit 1 = receive-ready), 2 is line status and 3 is the divisor (bits 3:0). Unused bits of the enable and divisor registers read 0. Read data appears on `rdata` one cycle after the `rd_en` cycle.
- R3: With divisor 0 no tick is produced: a byte written to the data register stays pending, the serial output stays high and line status reads 0x00.
- R4: Each bit on the serial output lasts exactly 16·BASE_DIV·divisor clock cycles.
- R5: A byte sent out through the serial output and fed back into the serial input is received unchanged at every divisor from 1 to 15.
- R6: Line status bit 5 (holding register empty) clears on a data write and sets when the byte moves into the shift register. Bit 6 is set only when the holding register is empty and the transmitter is idle.
- R7: Line status bit 0 (data ready) sets when a frame completes and clears when the data register is read.
- R8: The interrupt output enable is high exactly when an enable bit is set. `irq_n` is low while (transmit-empty enable and bit 5) or (receive-ready enable and bit 0) holds.
- R9: A frame that completes while bit 0 is still set sets overrun (bit 1), and the data register then holds the newer byte. A line status read clears bit 1.
- R10: A stop bit sampled low sets framing error (bit 2) and the byte is still delivered. A line status read clears bit 2.
- R11: A low pulse on the serial input that is shorter than half a bit is rejected as a false start and sets no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tx | output | 1 | Serial output |
| rx | input | 1 | Serial input |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Output enable for irq_n |

## Verification
The bench keeps the default `BASE_DIV` of 2 and `DIV_W` of 4. A single bit then takes only 32 clock cycles at divisor 1 and 480 at divisor 15. This makes it affordable to loop the serial output back into the input at all fifteen non-zero divisors, to measure the exact bit width at two of them, and to stack two frames for the overrun case. With the loop opened, the bench drives the serial input itself to build a frame with a low stop bit and a glitch too short to count as a start bit.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int OS_RATE   = 16;
    localparam int DATA_BITS = 8;

    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_FE   = 2;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_IEN  = 2'd1,
        REG_LSR  = 2'd2,
        REG_DIV  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_STOP
    } phase_e;

    // bit 1 = receive-ready enable, bit 0 = transmit-empty enable
    typedef struct packed {
        logic ie_rx;
        logic ie_tx;
    } ien_t;

    function automatic logic [7:0] pack_lsr(input logic dr, input logic oe,
                                            input logic fe, input logic thre,
                                            input logic temt);
        logic [7:0] v;
        v           = 8'h00;
        v[LSR_DR]   = dr;
        v[LSR_OE]   = oe;
        v[LSR_FE]   = fe;
        v[LSR_THRE] = thre;
        v[LSR_TEMT] = temt;
        return v;
    endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
    parameter int BASE_DIV = 2,
    parameter int DIV_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             os_tick
);
    localparam int PRE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] dcnt;
    logic             base_tick;
    logic             running;

    assign running   = (div != '0);
    assign base_tick = (pre == PRE_W'(BASE_DIV - 1));
    assign os_tick   = running && base_tick && (dcnt >= div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            pre  <= '0;
            dcnt <= '0;
        end else begin
            pre <= base_tick ? '0 : pre + PRE_W'(1);
            if (base_tick)
                dcnt <= (dcnt >= div - DIV_W'(1)) ? '0 : dcnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic       tx,
    output logic       thre,
    output logic       idle
);
    localparam logic [3:0] LAST_TICK = 4'(OS_RATE - 1);
    localparam logic [2:0] LAST_BIT  = 3'(DATA_BITS - 1);

    logic [7:0] thr, sh;
    logic       full, line;
    phase_e     ph;
    logic [3:0] tcnt;
    logic [2:0] bidx;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr  <= '0;
            sh   <= '0;
            full <= 1'b0;
            line <= 1'b1;
            ph   <= PH_IDLE;
            tcnt <= '0;
            bidx <= '0;
        end else begin
            if (os_tick) begin
                case (ph)
                    PH_IDLE: if (full) begin
                        sh   <= thr;
                        full <= 1'b0;
                        line <= 1'b0;
                        tcnt <= '0;
                        ph   <= PH_START;
                    end
                    PH_START: if (tcnt == LAST_TICK) begin
                        line <= sh[0];
                        sh   <= sh >> 1;
                        bidx <= '0;
                        tcnt <= '0;
                        ph   <= PH_DATA;
                    end else tcnt <= tcnt + 4'd1;
                    PH_DATA: if (tcnt == LAST_TICK) begin
                        tcnt <= '0;
                        if (bidx == LAST_BIT) begin
                            line <= 1'b1;
                            ph   <= PH_STOP;
                        end else begin
                            line <= sh[0];
                            sh   <= sh >> 1;
                            bidx <= bidx + 3'd1;
                        end
                    end else tcnt <= tcnt + 4'd1;
                    default: if (tcnt == LAST_TICK) begin
                        tcnt <= '0;
                        ph   <= PH_IDLE;
                    end else tcnt <= tcnt + 4'd1;
                endcase
            end
            if (wr_stb) begin
                thr  <= wr_data;
                full <= 1'b1;
            end
        end
    end

    assign tx   = line;
    assign thre = !full;
    assign idle = (ph == PH_IDLE);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rx,
    output logic       done,
    output logic [7:0] data,
    output logic       stop_ok
);
    localparam logic [3:0] LAST_TICK = 4'(OS_RATE - 1);
    localparam logic [3:0] MID_TICK  = 4'(OS_RATE / 2 - 1);
    localparam logic [2:0] LAST_BIT  = 3'(DATA_BITS - 1);

    logic       rs1, rs2, rprev;
    phase_e     ph;
    logic [3:0] cnt;
    logic [2:0] bidx;
    logic [7:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rs1     <= 1'b1;
            rs2     <= 1'b1;
            rprev   <= 1'b1;
            ph      <= PH_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            sh      <= '0;
            done    <= 1'b0;
            data    <= '0;
            stop_ok <= 1'b1;
        end else begin
            rs1   <= rx;
            rs2   <= rs1;
            rprev <= rs2;
            done  <= 1'b0;
            case (ph)
                PH_IDLE: if (rprev && !rs2) begin
                    cnt <= '0;
                    ph  <= PH_START;
                end
                PH_START: if (os_tick) begin
                    if (cnt == MID_TICK) begin
                        cnt  <= '0;
                        bidx <= '0;
                        ph   <= rs2 ? PH_IDLE : PH_DATA;
                    end else cnt <= cnt + 4'd1;
                end
                PH_DATA: if (os_tick) begin
                    if (cnt == LAST_TICK) begin
                        cnt <= '0;
                        sh  <= {rs2, sh[7:1]};
                        if (bidx == LAST_BIT) ph <= PH_STOP;
                        else bidx <= bidx + 3'd1;
                    end else cnt <= cnt + 4'd1;
                end
                default: if (os_tick) begin
                    if (cnt == LAST_TICK) begin
                        cnt     <= '0;
                        done    <= 1'b1;
                        data    <= sh;
                        stop_ok <= rs2;
                        ph      <= PH_IDLE;
                    end else cnt <= cnt + 4'd1;
                end
            endcase
        end
    end
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import uart_pkg::*;
#(
    parameter int BASE_DIV = 2,
    parameter int DIV_W    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       tx,
    input  logic       rx,
    output logic       irq_n,
    output logic       irq_oe
);
    ien_t             ien;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       rbr, rdata_q, rx_data;
    logic             dr, oe, fe;
    logic             os_tick, thre, tx_idle, rx_done, stop_ok;
    logic             wr_data_stb, rd_data_stb, rd_lsr_stb;
    logic [7:0]       rd_mux;

    assign wr_data_stb = wr_en && (addr == REG_DATA);
    assign rd_data_stb = rd_en && (addr == REG_DATA);
    assign rd_lsr_stb  = rd_en && (addr == REG_LSR);

    uart_tick_gen #(.BASE_DIV(BASE_DIV), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(div_q), .os_tick(os_tick)
    );

    uart_tx u_tx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .wr_stb(wr_data_stb),
        .wr_data(wdata), .tx(tx), .thre(thre), .idle(tx_idle)
    );

    uart_rx u_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx(rx),
        .done(rx_done), .data(rx_data), .stop_ok(stop_ok)
    );

    always_comb begin
        case (reg_sel_e'(addr))
            REG_DATA: rd_mux = rbr;
            REG_IEN:  rd_mux = {6'b0, ien};
            REG_LSR:  rd_mux = pack_lsr(dr, oe, fe, thre, thre && tx_idle);
            default:  rd_mux = 8'(div_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien     <= '0;
            div_q   <= '0;
            rbr     <= '0;
            dr      <= 1'b0;
            oe      <= 1'b0;
            fe      <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (wr_en && addr == REG_IEN) ien   <= ien_t'(wdata[1:0]);
            if (wr_en && addr == REG_DIV) div_q <= wdata[DIV_W-1:0];
            if (rd_data_stb) dr <= 1'b0;
            if (rd_lsr_stb) begin
                oe <= 1'b0;
                fe <= 1'b0;
            end
            if (rx_done) begin
                rbr <= rx_data;
                dr  <= 1'b1;
                if (dr && !rd_data_stb) oe <= 1'b1;
                if (!stop_ok) fe <= 1'b1;
            end
            if (rd_en) rdata_q <= rd_mux;
        end
    end

    assign rdata  = rdata_q;
    assign irq_oe = ien.ie_tx || ien.ie_rx;
    assign irq_n  = !((ien.ie_tx && thre) || (ien.ie_rx && dr));
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk #(
    parameter int DIV_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic             tx,
    input logic             irq_n,
    input logic             irq_oe,
    input logic             dr,
    input logic             thre,
    input logic             rx_done,
    input logic [DIV_W-1:0] div_q,
    input logic             ie_rx
);
    // R3: a halted divisor freezes the serial output
    assert_halt_freezes_tx_R3: assert property (@(posedge clk) disable iff (rst)
        (div_q == '0) |=> $stable(tx));

    // R6: a data write leaves the holding register occupied
    assert_write_clears_thre_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0) |=> !thre);

    // R7: reading the data register drops data ready unless a frame lands
    assert_read_clears_dr_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd0 && !rx_done) |=> !dr);

    // R8: a new byte with receive-ready enabled pulls the line low and drives it
    assert_rx_irq_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(dr) && ie_rx) |-> (!irq_n && irq_oe));

    // R9: a completed frame with data still pending keeps data ready set
    assert_overrun_keeps_dr_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && dr) |=> dr);
endmodule

bind mmio_uart mmio_uart_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .tx(tx), .irq_n(irq_n), .irq_oe(irq_oe), .dr(dr), .thre(thre),
    .rx_done(rx_done), .div_q(div_q), .ie_rx(ien.ie_rx)
);

// File: tb/sim_mmio_uart.sv
module sim_mmio_uart;
    localparam int BASE_DIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tx, irq_n, irq_oe;
    logic       loop = 1'b1, rx_drv = 1'b1;
    logic       rx_in;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    assign rx_in = loop ? tx : rx_drv;

    always #2.5 clk = ~clk;

    mmio_uart #(.BASE_DIV(BASE_DIV), .DIV_W(4)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tx(tx), .rx(rx_in),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // driver: queue the expected byte, then hand it to the transmitter
    task automatic drive_byte(input logic [7:0] b);
        exp_q.push_back(b);
        bus_wr(2'd0, b);
    endtask

    // monitor: wait for data ready, fetch the byte and compare with the queue
    task automatic monitor_pop(input string req);
        logic [7:0] s, d, e;
        int n;
        n = 0;
        s = 8'h00;
        while (s[0] !== 1'b1 && n < 20000) begin
            bus_rd(2'd2, s);
            n++;
        end
        bus_rd(2'd0, d);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        check(req, int'(d), int'(e));
    endtask

    task automatic bit_width(input int dv);
        int n, w;
        n = 0; w = 0;
        while (tx !== 1'b0 && n < 10000) begin @(negedge clk); n++; end
        while (tx === 1'b0 && w < 10000) begin @(negedge clk); w++; end
        check("R4 bit width", w, 16 * BASE_DIV * dv);
    endtask

    task automatic drive_frame(input logic [7:0] b, input logic stop, input int per);
        rx_drv = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (per) @(negedge clk);
        end
        rx_drv = stop;
        repeat (per) @(negedge clk);
        rx_drv = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 tx idle", int'(tx), 1);
        check("R1 irq_oe", int'(irq_oe), 0);
        bus_rd(2'd2, v); check("R1 lsr", int'(v), 8'h60);
        bus_rd(2'd3, v); check("R1 div", int'(v), 0);
        bus_rd(2'd1, v); check("R1 ien", int'(v), 0);

        // R2 register map and unused bits
        bus_wr(2'd1, 8'hFF); bus_rd(2'd1, v); check("R2 ien readback", int'(v), 8'h03);
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd3, 8'hF7); bus_rd(2'd3, v); check("R2 div readback", int'(v), 8'h07);
        bus_wr(2'd3, 8'h00);

        // R3 halted generator, R6 write clears THRE
        drive_byte(8'h55);
        repeat (200) @(negedge clk);
        check("R3 tx held high", int'(tx), 1);
        bus_rd(2'd2, v); check("R3 R6 lsr pending", int'(v), 8'h00);

        // R4 bit width at divisor 1, R6 THRE sets at load
        bus_wr(2'd3, 8'd1);
        bit_width(1);
        bus_rd(2'd2, v); check("R6 thre set, temt clear", int'(v & 8'h60), 8'h20);
        monitor_pop("R5 loopback byte after halt");
        bus_rd(2'd2, v); check("R7 dr cleared by read", int'(v[0]), 0);

        // R4 bit width at divisor 12
        bus_wr(2'd3, 8'd12);
        drive_byte(8'h01);
        bit_width(12);
        monitor_pop("R5 loopback div 12");

        // R5 every divisor
        for (int d = 1; d < 16; d++) begin
            bus_wr(2'd3, 8'(d));
            drive_byte(8'h3C ^ 8'(d * 17));
            monitor_pop($sformatf("R5 loopback div %0d", d));
        end
        bus_wr(2'd3, 8'd2);
        drive_byte(8'h00); monitor_pop("R5 pattern 00");
        drive_byte(8'hFF); monitor_pop("R5 pattern FF");
        drive_byte(8'hA5); monitor_pop("R5 pattern A5");

        // R8 interrupt behaviour
        bus_wr(2'd3, 8'd1);
        repeat (400) @(negedge clk);
        bus_wr(2'd1, 8'h00);
        check("R8 released with no enable", int'(irq_oe), 0);
        bus_wr(2'd1, 8'h02);
        check("R8 driven with rx enable", int'(irq_oe), 1);
        check("R8 idle high with no data", int'(irq_n), 1);
        drive_byte(8'h96);
        n = 0;
        while (irq_n !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
        check("R8 rx irq asserted", int'(irq_n), 0);
        bus_rd(2'd2, v); check("R7 dr set at irq", int'(v[0]), 1);
        monitor_pop("R5 loopback under rx irq");
        check("R8 rx irq cleared after read", int'(irq_n), 1);
        bus_wr(2'd1, 8'h01);
        repeat (400) @(negedge clk);
        check("R8 tx-empty irq low", int'(irq_n), 0);
        drive_byte(8'h3A);
        check("R8 irq released by write", int'(irq_n), 1);
        n = 0;
        while (irq_n !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
        check("R8 R6 irq returns at load", int'(n <= 16 * BASE_DIV), 1);
        bus_wr(2'd1, 8'h00);
        monitor_pop("R5 loopback under tx irq");

        // R9 overrun
        bus_wr(2'd0, 8'h11);
        repeat (40) @(negedge clk);
        bus_wr(2'd0, 8'h22);
        repeat (1000) @(negedge clk);
        bus_rd(2'd2, v); check("R9 overrun set", int'(v), 8'h63);
        bus_rd(2'd2, v); check("R9 overrun cleared by lsr read", int'(v), 8'h61);
        bus_rd(2'd0, v); check("R9 newest byte kept", int'(v), 8'h22);

        // R10 framing error
        loop = 1'b0;
        drive_frame(8'h5A, 1'b0, 16 * BASE_DIV);
        repeat (100) @(negedge clk);
        bus_rd(2'd2, v); check("R10 framing error", int'(v), 8'h65);
        bus_rd(2'd0, v); check("R10 byte delivered", int'(v), 8'h5A);
        bus_rd(2'd2, v); check("R10 fe cleared", int'(v), 8'h60);

        // R11 false start rejection
        rx_drv = 1'b0;
        repeat (6) @(negedge clk);
        rx_drv = 1'b1;
        repeat (600) @(negedge clk);
        bus_rd(2'd2, v); check("R11 glitch ignored", int'(v), 8'h60);
        loop = 1'b1;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule